// File: doc/BRIEF.md
# Slot-Based Output Contention Controller

This block is the decision logic of a bufferless N-port broadcast-and-select switch. At the start of each time slot, every input that holds a packet presents a valid flag and the destination label carried with that packet. The controller decodes each label into a request for one output. Each output then settles its own contention on its own. It raises a single gate enable for the input that wins, and it answers every requesting input with either an acknowledge (forwarded) or a negative acknowledge (blocked, so the sender retransmits).

Two priority modes are available. In fixed mode the lowest-numbered requesting input always wins. In round-robin mode each output keeps a pointer to its highest-priority input, and after every grant that pointer moves to the input just after the winner. Decisions are registered on the clock edge that samples the slot strobe. They stay unchanged for the rest of the slot, so the gate drivers see a steady setting well before the payload arrives.

Top module: `slot_contention_ctrl`

## Requirements
- R1: After reset, every gate enable, acknowledge and negative acknowledge is 0, and every round-robin pointer starts at input 0.
- R2: An input with its valid flag high and a label value L lower than NUM_PORTS requests output L. Input i's label occupies bits [i*LBL_W +: LBL_W] of `reqLabel`.
- R3: When `rrMode` is 0 in a slot, each output grants the lowest-indexed input that requests it.
- R4: When `rrMode` is 1 in a slot, each output searches upward (with wraparound) from its pointer. After that output grants input k, its pointer becomes (k+1) mod NUM_PORTS. Pointers change only in round-robin slots and only for outputs that granted.
- R5: `gateEn` bit o*NUM_PORTS+i enables input i onto output o. No output ever has more than one of its enables set.
- R6: Every input that wins gets its `ackOut` bit. Every valid requester that loses gets its `nackOut` bit. No input ever gets both.
- R7: An input whose valid flag is low, or whose label is NUM_PORTS or greater, gets no gate, no acknowledge and no negative acknowledge.
- R8: Results appear on the clock edge that samples `slotStart` high. They do not change, whatever the inputs do, until the next edge that samples `slotStart` high.
- R9: Each output with at least one requester grants exactly one input in that slot, independent of the other outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slotStart | input | 1 | Strobe marking the cycle in which requests are sampled |
| rrMode | input | 1 | 1 selects round-robin priority, 0 selects fixed lowest-index priority |
| reqValid | input | NUM_PORTS | Per-input packet-present flag |
| reqLabel | input | NUM_PORTS*LBL_W | Packed destination labels, one field per input |
| gateEn | output | NUM_PORTS*NUM_PORTS | Gate enables, NUM_PORTS bits per output |
| ackOut | output | NUM_PORTS | Per-input forward acknowledge |
| nackOut | output | NUM_PORTS | Per-input blocked indication |

## Verification
The gates, acknowledges and negative acknowledges all come out of one register stage. Each is due on the first rising edge after inputs are driven with `slotStart` high, so the bench drives on a falling edge and compares on the next falling edge. During the idle cycles between slots the bench scrambles every input and compares the outputs against the values held from the last slot. This covers the hold rule. A pointer update made by one round-robin slot only shows up in the winner of the next slot on that output, so the bench's model carries its pointers forward from slot to slot.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  // Strobes issued by the slot control to the arbitration datapath.
  typedef struct packed {
    logic load;    // capture decisions this cycle
    logic rotate;  // advance round-robin pointers for granting outputs
    logic useRr;   // search from the stored pointer instead of input 0
  } slotStrobe_t;
endpackage

// File: rtl/slot_arb_ctrl.sv
module slot_arb_ctrl
  import slot_arb_pkg::*;
(
  input  logic        slotStart,
  input  logic        rrMode,
  output slotStrobe_t strb
);
  always_comb begin
    strb.load   = slotStart;
    strb.useRr  = rrMode;
    strb.rotate = slotStart & rrMode;
  end
endmodule

// File: rtl/slot_arb_datapath.sv
module slot_arb_datapath
  import slot_arb_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int LBL_W     = $clog2(NUM_PORTS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  slotStrobe_t                  strb,
  input  logic [NUM_PORTS-1:0]         reqValid,
  input  logic [NUM_PORTS*LBL_W-1:0]   reqLabel,
  output logic [NUM_PORTS*NUM_PORTS-1:0] gateEn,
  output logic [NUM_PORTS-1:0]         ackOut,
  output logic [NUM_PORTS-1:0]         nackOut
);
  localparam int GATE_W = NUM_PORTS * NUM_PORTS;

  logic [NUM_PORTS-1:0] validLbl;
  logic [NUM_PORTS-1:0] reqMat [NUM_PORTS];   // [output][input]
  logic [GATE_W-1:0]    grantFlat;
  logic [NUM_PORTS-1:0] ackNext, nackNext;
  logic [GATE_W-1:0]    gateReg;
  logic [NUM_PORTS-1:0] ackReg, nackReg;

  // Label decode: valid flag and in-range label make a request (R2, R7).
  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      validLbl[i] = reqValid[i] &&
        ({1'b0, reqLabel[i*LBL_W +: LBL_W]} < (LBL_W+1)'(NUM_PORTS));
    end
    for (int o = 0; o < NUM_PORTS; o++) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        reqMat[o][i] = validLbl[i] && (reqLabel[i*LBL_W +: LBL_W] == LBL_W'(o));
      end
    end
  end

  // One independent arbiter per output.
  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    logic [LBL_W-1:0]     rrPtr;
    logic [NUM_PORTS-1:0] grant;
    logic [LBL_W-1:0]     winIdx;
    logic                 anyReq;

    always_comb begin
      int startIdx;
      grant    = '0;
      winIdx   = '0;
      anyReq   = 1'b0;
      startIdx = strb.useRr ? int'(rrPtr) : 0;
      for (int k = 0; k < NUM_PORTS; k++) begin
        int idx;
        idx = (startIdx + k) % NUM_PORTS;
        if (!anyReq && reqMat[o][idx]) begin
          anyReq      = 1'b1;
          grant[idx]  = 1'b1;
          winIdx      = idx[LBL_W-1:0];
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rrPtr <= '0;
      end else if (strb.rotate && anyReq) begin
        rrPtr <= (winIdx == LBL_W'(NUM_PORTS-1)) ? '0 : winIdx + 1'b1;
      end
    end

    assign grantFlat[o*NUM_PORTS +: NUM_PORTS] = grant;

    p_gate_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(gateReg[o*NUM_PORTS +: NUM_PORTS]));

    p_work_conserve_r9: assert property (@(posedge clk) disable iff (!rstN)
      (strb.load && (|reqMat[o])) |=> (|gateReg[o*NUM_PORTS +: NUM_PORTS]));

    p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rstN)
      int'(rrPtr) < NUM_PORTS);
  end

  always_comb begin
    ackNext = '0;
    for (int o = 0; o < NUM_PORTS; o++) begin
      ackNext = ackNext | grantFlat[o*NUM_PORTS +: NUM_PORTS];
    end
    nackNext = validLbl & ~ackNext;
  end

  // Decisions held for the whole slot (R8).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateReg <= '0;
      ackReg  <= '0;
      nackReg <= '0;
    end else if (strb.load) begin
      gateReg <= grantFlat;
      ackReg  <= ackNext;
      nackReg <= nackNext;
    end
  end

  assign gateEn  = gateReg;
  assign ackOut  = ackReg;
  assign nackOut = nackReg;

  p_ack_nack_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackReg & nackReg) == '0);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_in
    logic gateAny;
    always_comb begin
      gateAny = 1'b0;
      for (int o = 0; o < NUM_PORTS; o++) gateAny = gateAny | gateReg[o*NUM_PORTS + i];
    end

    p_gate_implies_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
      gateAny |-> ackReg[i]);

    p_invalid_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
      (strb.load && !validLbl[i]) |=> (!ackReg[i] && !nackReg[i]));
  end

  p_hold_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(ackReg) && $stable(nackReg)));
endmodule

// File: rtl/slot_contention_ctrl.sv
module slot_contention_ctrl
  import slot_arb_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int LBL_W     = $clog2(NUM_PORTS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           slotStart,
  input  logic                           rrMode,
  input  logic [NUM_PORTS-1:0]           reqValid,
  input  logic [NUM_PORTS*LBL_W-1:0]     reqLabel,
  output logic [NUM_PORTS*NUM_PORTS-1:0] gateEn,
  output logic [NUM_PORTS-1:0]           ackOut,
  output logic [NUM_PORTS-1:0]           nackOut
);
  slotStrobe_t strb;

  slot_arb_ctrl u_ctrl (
    .slotStart (slotStart),
    .rrMode    (rrMode),
    .strb      (strb)
  );

  slot_arb_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .LBL_W     (LBL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqValid (reqValid),
    .reqLabel (reqLabel),
    .gateEn   (gateEn),
    .ackOut   (ackOut),
    .nackOut  (nackOut)
  );
endmodule

// File: tb/sim_slot_contention_ctrl.sv
module sim_slot_contention_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int W = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slotStart = 1'b0;
  logic rrMode = 1'b0;
  logic [N-1:0]   reqValid = '0;
  logic [N*W-1:0] reqLabel = '0;
  logic [N*N-1:0] gateEn;
  logic [N-1:0]   ackOut, nackOut;

  int vecCount = 0;
  int failCount = 0;
  bit done = 0;
  int mPtr [N];
  logic [N*N-1:0] expGate;
  logic [N-1:0]   expAck, expNack;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_contention_ctrl #(.NUM_PORTS(N)) u0 (
    .clk(clk), .rstN(rstN), .slotStart(slotStart), .rrMode(rrMode),
    .reqValid(reqValid), .reqLabel(reqLabel),
    .gateEn(gateEn), .ackOut(ackOut), .nackOut(nackOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model built from R2..R7, R9; advances pointers per R4.
  task automatic model(input logic [N-1:0] v, input logic [N*W-1:0] l, input bit rr);
    expGate = '0; expAck = '0; expNack = '0;
    for (int o = 0; o < N; o++) begin
      bit found = 0;
      int start = rr ? mPtr[o] : 0;
      for (int k = 0; k < N; k++) begin
        int idx = (start + k) % N;
        if (!found && v[idx] && int'(l[idx*W +: W]) == o) begin
          found = 1;
          expGate[o*N + idx] = 1'b1;
          expAck[idx] = 1'b1;
          if (rr) mPtr[o] = (idx + 1) % N;
        end
      end
    end
    for (int i = 0; i < N; i++)
      if (v[i] && int'(l[i*W +: W]) < N && !expAck[i]) expNack[i] = 1'b1;
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " gate"}, 32'(gateEn), 32'(expGate));
    chk({tag, " ack"},  32'(ackOut), 32'(expAck));
    chk({tag, " nack"}, 32'(nackOut), 32'(expNack));
  endtask

  task automatic runSlot(input logic [N-1:0] v, input logic [N*W-1:0] l,
                         input bit rr, input string tag, input int idle);
    @(negedge clk);
    reqValid = v; reqLabel = l; rrMode = rr; slotStart = 1'b1;
    model(v, l, rr);
    @(negedge clk);
    slotStart = 1'b0;
    checkAll(tag);
    for (int c = 0; c < idle; c++) begin
      reqValid = N'($urandom); reqLabel = (N*W)'($urandom); rrMode = 1'($urandom);
      @(negedge clk);
      checkAll("R8 hold");
    end
  endtask

  function automatic logic [N*W-1:0] allTo(input int d);
    logic [N*W-1:0] r = '0;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(d);
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] perm;
    void'($urandom(32'd7331));
    for (int o = 0; o < N; o++) mPtr[o] = 0;
    repeat (3) @(negedge clk);
    chk("R1 gate", 32'(gateEn), 32'd0);
    chk("R1 ack", 32'(ackOut), 32'd0);
    chk("R1 nack", 32'(nackOut), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'(ackOut | nackOut), 32'd0);

    // R3: all inputs to output 2, fixed priority: input 0 wins.
    runSlot('1, allTo(2), 1'b0, "R3 fixed all-to-2", 2);
    chk("R3 winner input0", 32'(gateEn[2*N +: N]), 32'd1);
    // R3: only inputs 3 and 4 contend -> input 3.
    runSlot(5'b11000, allTo(1), 1'b0, "R3 fixed pair", 1);
    // R4: repeated round-robin on output 0 visits 0,1,2,3,4,0.
    for (int s = 0; s < 6; s++) begin
      runSlot('1, allTo(0), 1'b1, "R4 rotate", 0);
      chk("R4 rotate winner", 32'(ackOut), 32'(1 << (s % N)));
    end
    // R2/R9: permutation, no contention, all forwarded.
    for (int i = 0; i < N; i++) perm[i*W +: W] = W'((i + 2) % N);
    runSlot('1, perm, 1'b0, "R2 R9 permutation", 1);
    chk("R9 all acked", 32'(ackOut), 32'h1f);
    // R7: out-of-range labels 5,6,7 and invalid flags are silent.
    runSlot('1, {3'd7, 3'd6, 3'd5, 3'd7, 3'd5}, 1'b0, "R7 out of range", 1);
    chk("R7 silent", 32'(ackOut | nackOut), 32'd0);
    runSlot('0, allTo(1), 1'b1, "R7 invalid flag", 1);
    // Random slots, mixed modes (R2..R9).
    for (int s = 0; s < 400; s++) begin
      logic [N*W-1:0] lr;
      for (int i = 0; i < N; i++) lr[i*W +: W] = W'($urandom % ((s % 3 == 0) ? 8 : N));
      runSlot(N'($urandom), lr, 1'($urandom), "R2 R3 R4 R6 random", int'($urandom % 3));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule